// File: doc/BRIEF.md
# Two-Round-Per-Cycle Stream Cipher Key Scheduler

This block prepares the 256-entry byte permutation used by an RC4-style keystream generator. After a start pulse it loads the identity permutation in one cycle. It then mixes in a key of 1 to 256 bytes, doing two scheduling rounds in every clock. Each cycle it reads the two key bytes it needs through a pair of combinational read addresses. It folds both rounds' swaps into one register update, and after 128 such cycles it raises a done flag. A keystream generator then reads the finished permutation through a combinational read port.

The control is a four-state machine. `ST_IDLE` waits for `start` and takes the transition *accept* to `ST_FILL`. `ST_FILL` writes the identity permutation and clears the mixing index; its transition *fill-complete* leads to `ST_MIX`. `ST_MIX` runs one double round per cycle. It takes the transition *schedule-end* to `ST_DONE` after the round pair (254, 255). `ST_DONE` holds the result with `done` high, and a new `start` there takes the transition *restart* back to `ST_FILL`. A start seen in `ST_FILL` or `ST_MIX` is dropped.

Top module: `rc4_dual_ksa`

## Requirements
- R1: While reset is held and after its release with no start, `done` is 0 and `perm_data` returns n for every `perm_addr` value n.
- R2: When `start` is sampled high at a rising edge E0 in the idle or done state, `done` is 0 up to and including edge E0+128 and is 1 after edge E0+129.
- R3: At done, location n of the permutation holds the value that the sequential schedule produces. That schedule starts from S[n]=n with j=0, and for i = 0..255 it sets j = (j + S[i] + key[i mod L]) mod 256 and then swaps S[i] and S[j]. L is the `key_len` sampled with the accepted start.
- R4: In update cycle c (c = 0..127, the cycle after edge E0+1+c), `key_addr_a` equals (2c) mod L and `key_addr_b` equals (2c+1) mod L. The bench returns key[addr] on `key_byte_a` / `key_byte_b` in the same cycle.
- R5: A `start` pulse while the fill or the update cycles run has no effect. The done timing of R2 and the result of R3 still follow the originally accepted start and key length, even if `key_len` changes.
- R6: A `start` in the done state restarts the schedule: `done` is 0 after the next edge and the result again follows R2 and R3 for the new key.
- R7: Key lengths 1 (every round uses key byte 0) and 256 (every key byte used once) give the R3 result.
- R8: Within one update cycle, the cases where the second round's index equals the first round's j, where the second j equals the first index, and where the two j values are equal, all give the R3 result.
- R9: Once done, `done` and the permutation contents hold while `start` stays low, and `perm_data` shows the byte at `perm_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a schedule (taken in idle or done state only) |
| key_len | input | 9 | Key length in bytes, 1 to 256, sampled with start |
| key_addr_a | output | 8 | Key byte address for the first round of the pair |
| key_addr_b | output | 8 | Key byte address for the second round of the pair |
| key_byte_a | input | 8 | Key byte at `key_addr_a`, same cycle |
| key_byte_b | input | 8 | Key byte at `key_addr_b`, same cycle |
| perm_addr | input | 8 | Permutation read address |
| perm_data | output | 8 | Permutation byte at `perm_addr`, combinational |
| done | output | 1 | Schedule finished, permutation valid |

## Verification
The two swaps of a round pair land in the same register update. When their indices overlap, one round's write-back can corrupt the other's. Two-byte keys are chosen so that the very first update cycle hits each overlap: the second index equals the first j, the second j equals the first index, or both j values match. Random keys of random length then provide further incidental overlaps. A second clash puts a start pulse, with a different key length, into the middle of the update cycles. Every case is judged by comparing all 256 bytes read back after done with a sequential one-round-at-a-time model in the bench.

// File: rtl/rc4ks_pkg.sv
package rc4ks_pkg;
    // number of write-back ports of a merged double swap
    localparam int NWR = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_MIX,
        ST_DONE
    } ks_state_t;
endpackage

// File: rtl/ks_index_ctr.sv
// Even round index plus the two running key positions (index mod length).
module ks_index_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W:0]   len,
    output logic [W-1:0] idx_even,
    output logic [W-1:0] kaddr_a,
    output logic [W-1:0] kaddr_b,
    output logic         last
);
    localparam int DEPTH = 1 << W;
    localparam logic [W-1:0] LAST_IDX = W'(DEPTH - 2);
    localparam logic [W-1:0] TWO_I    = W'(2);
    localparam logic [W+1:0] TWO_K    = (W+2)'(2);
    localparam logic [W:0]   ONE_L    = (W+1)'(1);

    logic [W-1:0] i_q;
    logic [W:0]   ka_q, kb_q;

    // advance a key position by two, wrapping modulo len (len may be 1)
    function automatic logic [W:0] adv2(input logic [W:0] x, input logic [W:0] m);
        logic [W+1:0] t;
        t = {1'b0, x} + TWO_K;
        if (t >= {1'b0, m}) t = t - {1'b0, m};
        if (t >= {1'b0, m}) t = t - {1'b0, m};
        return t[W:0];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q  <= '0;
            ka_q <= '0;
            kb_q <= '0;
        end else if (load) begin
            i_q  <= '0;
            ka_q <= '0;
            kb_q <= (len == ONE_L) ? '0 : ONE_L;
        end else if (step) begin
            i_q  <= i_q + TWO_I;
            ka_q <= adv2(ka_q, len);
            kb_q <= adv2(kb_q, len);
        end
    end

    assign idx_even = i_q;
    assign kaddr_a  = ka_q[W-1:0];
    assign kaddr_b  = kb_q[W-1:0];
    assign last     = (i_q == LAST_IDX);
endmodule

// File: rtl/ks_dual_round.sv
// Combinational merge of two consecutive scheduling rounds into four writes.
module ks_dual_round
    import rc4ks_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [(1<<W)-1:0][W-1:0] cells,
    input  logic [W-1:0]             i1,
    input  logic [W-1:0]             j0,
    input  logic [W-1:0]             k1,
    input  logic [W-1:0]             k2,
    output logic [W-1:0]             j2,
    output logic [NWR-1:0][W-1:0]    wa,
    output logic [NWR-1:0][W-1:0]    wd
);
    logic [W-1:0] i2, j1;
    logic [W-1:0] v_i1, v_j1, v_i2, v_j2;
    logic [W-1:0] s1_i2, s1_j2;

    always_comb begin
        i2    = {i1[W-1:1], 1'b1};
        v_i1  = cells[i1];
        j1    = j0 + v_i1 + k1;
        v_j1  = cells[j1];
        v_i2  = cells[i2];
        // first swap moved S[i1] into slot j1
        s1_i2 = (i2 == j1) ? v_i1 : v_i2;
        j2    = j1 + s1_i2 + k2;
        v_j2  = cells[j2];
        if (j2 == i1)      s1_j2 = v_j1;
        else if (j2 == j1) s1_j2 = v_i1;
        else               s1_j2 = v_j2;
        // ordered writes: a later port overrides an earlier one on the same slot
        wa[0] = i1;  wd[0] = v_j1;
        wa[1] = j1;  wd[1] = v_i1;
        wa[2] = i2;  wd[2] = s1_j2;
        wa[3] = j2;  wd[3] = s1_i2;
    end
endmodule

// File: rtl/ks_perm_bank.sv
// Register-based permutation with identity fill and a four-write ordered update.
module ks_perm_bank
    import rc4ks_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fill,
    input  logic                     upd,
    input  logic [NWR-1:0][W-1:0]    wa,
    input  logic [NWR-1:0][W-1:0]    wd,
    output logic [(1<<W)-1:0][W-1:0] cells
);
    localparam int DEPTH = 1 << W;

    for (genvar n = 0; n < DEPTH; n++) begin : g_cell
        localparam logic [W-1:0] IDV = W'(n);
        logic [W-1:0] q, d;

        always_comb begin
            d = q;
            for (int p = 0; p < NWR; p++) begin
                if (wa[p] == IDV) d = wd[p];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= IDV;
            else if (fill) q <= IDV;
            else if (upd)  q <= d;
        end

        assign cells[n] = q;
    end
endmodule

// File: rtl/rc4_dual_ksa.sv
module rc4_dual_ksa
    import rc4ks_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W:0]   key_len,
    output logic [W-1:0] key_addr_a,
    output logic [W-1:0] key_addr_b,
    input  logic [W-1:0] key_byte_a,
    input  logic [W-1:0] key_byte_b,
    input  logic [W-1:0] perm_addr,
    output logic [W-1:0] perm_data,
    output logic         done
);
    localparam int DEPTH = 1 << W;

    ks_state_t st_q, st_d;
    logic      accept, fill_en, mix_en, last;
    logic [W:0]   len_q;
    logic [W-1:0] j_q, j_nx, i_even;
    logic [DEPTH-1:0][W-1:0] cells;
    logic [NWR-1:0][W-1:0]   wa, wd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions: accept, fill-complete, schedule-end, restart
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_FILL;
            ST_FILL: st_d = ST_MIX;
            ST_MIX:  if (last)  st_d = ST_DONE;
            ST_DONE: if (start) st_d = ST_FILL;
        endcase
    end

    // state-decoded controls
    always_comb begin
        accept  = 1'b0;
        fill_en = 1'b0;
        mix_en  = 1'b0;
        done    = 1'b0;
        unique case (st_q)
            ST_IDLE: accept = start;
            ST_FILL: fill_en = 1'b1;
            ST_MIX:  mix_en = 1'b1;
            ST_DONE: begin
                done   = 1'b1;
                accept = start;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            j_q   <= '0;
        end else begin
            if (accept)  len_q <= key_len;
            if (fill_en) j_q   <= '0;
            else if (mix_en) j_q <= j_nx;
        end
    end

    ks_index_ctr #(.W(W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fill_en),
        .step     (mix_en),
        .len      (len_q),
        .idx_even (i_even),
        .kaddr_a  (key_addr_a),
        .kaddr_b  (key_addr_b),
        .last     (last)
    );

    ks_dual_round #(.W(W)) u_round (
        .cells (cells),
        .i1    (i_even),
        .j0    (j_q),
        .k1    (key_byte_a),
        .k2    (key_byte_b),
        .j2    (j_nx),
        .wa    (wa),
        .wd    (wd)
    );

    ks_perm_bank #(.W(W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .fill  (fill_en),
        .upd   (mix_en),
        .wa    (wa),
        .wd    (wd),
        .cells (cells)
    );

    assign perm_data = cells[perm_addr];
endmodule

// File: rtl/rc4_dual_ksa_chk.sv
module rc4_dual_ksa_chk
    import rc4ks_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input ks_state_t    st,
    input logic [W-1:0] key_addr_a,
    input logic [W-1:0] key_addr_b,
    input logic [W:0]   len_q
);
    localparam logic [W:0] ONE_L = (W+1)'(1);

    // R9: result held while no new start
    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R6: start in done state drops done on the next edge
    a_r6_restart_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);

    // R4: key addresses stay inside the key
    a_r4_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MIX) |-> ({1'b0, key_addr_a} < len_q && {1'b0, key_addr_b} < len_q));

    // R4: second address is the successor of the first, modulo the length
    a_r4_addr_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MIX) |->
        ({1'b0, key_addr_b} == (({1'b0, key_addr_a} + ONE_L == len_q) ? '0
                                 : {1'b0, key_addr_a} + ONE_L)));

    // R2: update cycles are always preceded by the identity fill
    a_r2_mix_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MIX && $past(st) != ST_MIX) |-> $past(st) == ST_FILL);

    // R5: a start during updates does not leave the schedule
    a_r5_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MIX && start) |=> (st == ST_MIX || st == ST_DONE));
endmodule

bind rc4_dual_ksa rc4_dual_ksa_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .st         (st_q),
    .key_addr_a (key_addr_a),
    .key_addr_b (key_addr_b),
    .len_q      (len_q)
);

// File: tb/rc4_dual_ksa_bench.sv
`timescale 1ns/1ps
module rc4_dual_ksa_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [8:0] key_len;
    logic [7:0] key_addr_a, key_addr_b, key_byte_a, key_byte_b;
    logic [7:0] perm_addr, perm_data;
    logic       done;

    logic [7:0] key_mem [256];
    logic [7:0] last_exp [256];
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;  // 250 MHz

    assign key_byte_a = key_mem[key_addr_a];
    assign key_byte_b = key_mem[key_addr_b];

    rc4_dual_ksa u_rc4_dual_ksa (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .key_len    (key_len),
        .key_addr_a (key_addr_a),
        .key_addr_b (key_addr_b),
        .key_byte_a (key_byte_a),
        .key_byte_b (key_byte_b),
        .perm_addr  (perm_addr),
        .perm_data  (perm_data),
        .done       (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // sequential one-round-at-a-time schedule
    task automatic ref_ksa(input int len, output logic [7:0] s [256]);
        int j;
        logic [7:0] t;
        j = 0;
        for (int n = 0; n < 256; n++) s[n] = 8'(n);
        for (int i = 0; i < 256; i++) begin
            j = (j + int'(s[i]) + int'(key_mem[i % len])) % 256;
            t = s[i]; s[i] = s[j[7:0]]; s[j[7:0]] = t;
        end
    endtask

    task automatic compare_perm(input string req, input string what);
        int nbad, ba, bg, be;
        nbad = 0; ba = 0; bg = 0; be = 0;
        for (int a = 0; a < 256; a++) begin
            perm_addr = 8'(a);
            #0.2;
            if (perm_data !== last_exp[a]) begin
                if (nbad == 0) begin ba = a; bg = int'(perm_data); be = int'(last_exp[a]); end
                nbad++;
            end
        end
        check(nbad == 0, req, $sformatf("%s at addr %0d", what, ba), bg, be);
    endtask

    task automatic run_key(input int len, input string req, input bit poke_busy);
        int bad, ga, ea;
        ref_ksa(len, last_exp);
        bad = 0; ga = 0; ea = 0;
        @(negedge clk);
        start = 1'b1; key_len = 9'(len);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R6", "done after accepted start", int'(done), 0);
        for (int k = 1; k <= 129; k++) begin
            @(negedge clk);
            if (poke_busy && k == 50) begin start = 1'b1; key_len = 9'((len == 1) ? 3 : 1); end
            if (poke_busy && k == 51) start = 1'b0;
            if (k <= 128) begin
                int c, xa, xb;
                c  = k - 1;
                xa = (2 * c) % len;
                xb = (2 * c + 1) % len;
                if (int'(key_addr_a) != xa || int'(key_addr_b) != xb) begin
                    if (bad == 0) begin ga = int'(key_addr_a); ea = xa; end
                    bad++;
                end
            end
            if (k == 128) check(done == 1'b0, "R2", "done early at edge 128", int'(done), 0);
        end
        check(done == 1'b1, "R2", "done after edge 129", int'(done), 1);
        check(bad == 0, "R4", "key address a", ga, ea);
        compare_perm(req, $sformatf("permutation len %0d", len));
        key_len = 9'(len);
    endtask

    initial begin
        #(4.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; key_len = 9'd1; perm_addr = 8'd0;
        for (int n = 0; n < 256; n++) begin key_mem[n] = 8'd0; last_exp[n] = 8'(n); end
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        compare_perm("R1", "identity in reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(done == 1'b0, "R1", "done idle", int'(done), 0);
        compare_perm("R1", "identity after reset");

        // R7: boundary key lengths
        run_key(1, "R7", 1'b0);
        for (int n = 0; n < 256; n++) key_mem[n] = 8'(n * 7 + 3);
        run_key(256, "R7", 1'b0);

        // R8: overlaps in the first update cycle
        key_mem[0] = 8'd1; key_mem[1] = 8'd0;    // second index equals first j
        run_key(2, "R8", 1'b0);
        key_mem[0] = 8'd0; key_mem[1] = 8'd255;  // second j equals first index
        run_key(2, "R8", 1'b0);
        key_mem[0] = 8'd5; key_mem[1] = 8'd255;  // both j equal
        run_key(2, "R8", 1'b0);

        // R3 / R5 / R6: random keys, back-to-back restarts, one busy start
        void'($urandom(32'd20240611));
        for (int r = 0; r < 6; r++) begin
            int len;
            len = 1 + int'($urandom % 256);
            for (int n = 0; n < 256; n++) key_mem[n] = 8'($urandom);
            run_key(len, (r == 2) ? "R5" : "R3", r == 2);
        end

        // R9: hold while start stays low
        repeat (20) @(negedge clk);
        check(done == 1'b1, "R9", "done held", int'(done), 1);
        compare_perm("R9", "permutation held");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule